// File: doc/BRIEF.md
# Latched Reset-Slave Release Decoder

This block is glue logic that lets a single reset master hold or release the boot-stop lines of as many as fifteen reset slaves while spending only five general-purpose outputs. Four of those outputs carry a slave index. The fifth is a level-sensitive latch enable. While the enable is high the index passes straight through to the decoder. While it is low, the last index that was present at a clock edge with the enable high is held. The decoded index pulls exactly one active-low stop line low. The reserved all-ones code, or any index at or beyond the configured slave count, releases every line.

Small systems with five or fewer slaves need no decoding. For them a compile-time mode passes the five master outputs straight through to stop lines 0 to 4 and ties the rest high. An active-low reset loads the release code, so every slave is released until the master names one.

Top module: `slvrel_top`

## Requirements
- R1: In decoded mode, while `le_i` is high, the stop outputs follow `sel_i` combinationally in the same cycle.
- R2: In decoded mode, while `le_i` is low, changes on `sel_i` have no effect. The outputs hold the value for the index that was present at the last rising clock edge with `le_i` high.
- R3: In decoded mode, an index i below NUM_SLAVES drives `stop_n_o[i]` low and every other stop output high. At most one output is ever low.
- R4: In decoded mode, the index 4'b1111 drives all fifteen stop outputs high.
- R5: NUM_SLAVES (1 to 15) limits the active lines. Outputs at positions NUM_SLAVES and above are always high, and an index of NUM_SLAVES or more releases every line.
- R6: In decoded mode, all stop outputs are high while `rst_n` is low. After reset they stay high until `le_i` is raised with an index.
- R7: In direct mode (DIRECT_MODE=1), `stop_n_o[k]` equals `sel_i[k]` for k from 0 to 3, and `stop_n_o[4]` equals `le_i`, each only when k is below min(NUM_SLAVES,5). All other outputs are high, and reset has no effect on the outputs.
- R8: The stop bus is always fifteen lines wide, one line for each index from 0 to 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the held index |
| rst_n | input | 1 | Asynchronous active-low reset; loads the release code |
| sel_i | input | 4 | Slave index from the master (direct mode: lines 0 to 3) |
| le_i | input | 1 | Latch enable, transparent when high (direct mode: line 4) |
| stop_n_o | output | 15 | Active-low boot-stop lines, one per slave |

## Verification
The bench builds three copies of the block. The first is decoded with NUM_SLAVES=15, which makes every one of the sixteen codes reachable, including the release code. The second is decoded with NUM_SLAVES=10, so that indices 10 to 14 exercise the release-above-count rule and the tied-high upper lines. The third is a direct-mode copy with NUM_SLAVES=4, which is swept over all 32 input combinations and shows line 4 tied high even while the enable toggles. All three share the stimulus, so each input pattern is judged against three independent, arithmetically computed expectations: transparent phase, held phase and reset.

// File: rtl/slvrel_pkg.sv
package slvrel_pkg;
    localparam int unsigned IDX_W    = 4;
    localparam int unsigned LINE_CNT = (1 << IDX_W) - 1;
    localparam int unsigned DIR_MAX  = 5;

    typedef logic [IDX_W-1:0] idx_t;

    typedef struct packed {
        idx_t idx;
    } hold_st;

    localparam idx_t IDX_RELEASE = '1;
endpackage

// File: rtl/slvrel_hold.sv
module slvrel_hold
    import slvrel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic le_i,
    input  idx_t sel_i,
    output idx_t idx_o
);
    hold_st hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (le_i) begin
            hold_d.idx = sel_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q.idx <= IDX_RELEASE;
        end else begin
            hold_q <= hold_d;
        end
    end

    // Transparent while enabled, otherwise the captured index; reset forces release.
    always_comb begin
        if (!rst_n) begin
            idx_o = IDX_RELEASE;
        end else if (le_i) begin
            idx_o = sel_i;
        end else begin
            idx_o = hold_q.idx;
        end
    end

    // R2: index seen by the decoder is frozen across a closed-latch interval
    a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_i && $past(!le_i)) |-> $stable(idx_o));
endmodule

// File: rtl/slvrel_decode.sv
module slvrel_decode
    import slvrel_pkg::*;
#(
    parameter int unsigned NUM_SLAVES = 15
) (
    input  idx_t                idx_i,
    output logic [LINE_CNT-1:0] stop_n_o
);
    localparam int unsigned ACT_N = (NUM_SLAVES > LINE_CNT) ? LINE_CNT : NUM_SLAVES;

    for (genvar k = 0; k < LINE_CNT; k++) begin : g_line
        if (k < ACT_N) begin : g_act
            assign stop_n_o[k] = (idx_i != IDX_W'(k));
        end else begin : g_tie
            assign stop_n_o[k] = 1'b1;
        end
    end
endmodule

// File: rtl/slvrel_direct.sv
module slvrel_direct
    import slvrel_pkg::*;
#(
    parameter int unsigned NUM_SLAVES = 5
) (
    input  idx_t                sel_i,
    input  logic                le_i,
    output logic [LINE_CNT-1:0] stop_n_o
);
    localparam int unsigned DIR_N = (NUM_SLAVES > DIR_MAX) ? DIR_MAX : NUM_SLAVES;

    logic [DIR_MAX-1:0] raw;
    assign raw = {le_i, sel_i};

    for (genvar k = 0; k < LINE_CNT; k++) begin : g_line
        if (k < DIR_N) begin : g_pass
            assign stop_n_o[k] = raw[k];
        end else begin : g_tie
            assign stop_n_o[k] = 1'b1;
        end
    end
endmodule

// File: rtl/slvrel_top.sv
module slvrel_top
    import slvrel_pkg::*;
#(
    parameter int unsigned NUM_SLAVES  = 15,
    parameter bit          DIRECT_MODE = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    sel_i,
    input  logic                le_i,
    output logic [LINE_CNT-1:0] stop_n_o
);
    localparam int unsigned ACT_N = (NUM_SLAVES < 1) ? 1 :
                                    (NUM_SLAVES > LINE_CNT) ? LINE_CNT : NUM_SLAVES;
    localparam int unsigned DIR_N = (ACT_N > DIR_MAX) ? DIR_MAX : ACT_N;

    idx_t                idx_eff;
    logic [LINE_CNT-1:0] dec_n;
    logic [LINE_CNT-1:0] dir_n;

    slvrel_hold u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .le_i  (le_i),
        .sel_i (sel_i),
        .idx_o (idx_eff)
    );

    slvrel_decode #(.NUM_SLAVES(ACT_N)) u_decode (
        .idx_i    (idx_eff),
        .stop_n_o (dec_n)
    );

    slvrel_direct #(.NUM_SLAVES(DIR_N)) u_direct (
        .sel_i    (sel_i),
        .le_i     (le_i),
        .stop_n_o (dir_n)
    );

    assign stop_n_o = DIRECT_MODE ? dir_n : dec_n;

    if (!DIRECT_MODE) begin : g_dec_chk
        // R3: never more than one slave held in stop
        a_r3_single_low: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(~stop_n_o));
        // R4: open latch carrying the release code frees every line
        a_r4_release_all: assert property (@(posedge clk) disable iff (!rst_n)
            (le_i && (sel_i == IDX_RELEASE)) |-> (&stop_n_o));
        // R6: reset keeps all slaves released
        a_r6_reset_release: assert property (@(posedge clk)
            !rst_n |-> (&stop_n_o));
        if (ACT_N < LINE_CNT) begin : g_upper
            // R5: lines beyond the slave count never go low
            a_r5_upper_high: assert property (@(posedge clk) disable iff (!rst_n)
                &stop_n_o[LINE_CNT-1:ACT_N]);
        end
    end else begin : g_dir_chk
        // R7: unused direct lines stay high
        a_r7_direct_tie: assert property (@(posedge clk)
            &stop_n_o[LINE_CNT-1:DIR_N]);
    end
endmodule

// File: tb/test_slvrel_top.sv
module test_slvrel_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 15;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   sel = 4'd0;
    logic         le = 1'b0;
    logic [W-1:0] out15, out10, outdir;
    int           n_chk = 0;
    int           n_err = 0;
    bit           done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slvrel_top #(.NUM_SLAVES(15), .DIRECT_MODE(1'b0)) i_slvrel_top (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .le_i(le), .stop_n_o(out15));
    slvrel_top #(.NUM_SLAVES(10), .DIRECT_MODE(1'b0)) i_slvrel_top_n10 (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .le_i(le), .stop_n_o(out10));
    slvrel_top #(.NUM_SLAVES(4), .DIRECT_MODE(1'b1)) i_slvrel_top_dir (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .le_i(le), .stop_n_o(outdir));

    function automatic logic [W-1:0] exp_dec(int code, int n);
        logic [W-1:0] v = '1;
        if (code < n) v[code] = 1'b0;
        return v;
    endfunction

    function automatic logic [W-1:0] exp_dir(logic [3:0] s, logic l, int n);
        logic [W-1:0] v = '1;
        logic [4:0] raw = {l, s};
        for (int k = 0; k < 5; k++) if (k < n) v[k] = raw[k];
        return v;
    endfunction

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [3:0] held;
        // R6: reset with an open latch and a live index
        le = 1'b1; sel = 4'd3;
        repeat (2) @(posedge clk);
        @(negedge clk); #1;
        chk("R6 reset n15", out15, '1);
        chk("R6 reset n10", out10, '1);
        chk("R7 direct ignores reset", outdir, exp_dir(4'd3, 1'b1, 4));
        // R8: fixed bus width
        n_chk++;
        if ($bits(out15) != 15) begin
            n_err++;
            $display("FAIL R8: got %0d expected 15", $bits(out15));
        end
        le = 1'b0; sel = 4'd5;
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); @(negedge clk); #1;
        chk("R6 post-reset released n15", out15, '1);
        chk("R6 post-reset released n10", out10, '1);

        // R1 R2 R3 R4 R5: every code, transparent then held
        for (int code = 0; code < 16; code++) begin
            @(negedge clk); le = 1'b1; sel = 4'(code); #1;
            chk("R1 R3 R4 open n15", out15, exp_dec(code, 15));
            chk("R5 open n10", out10, exp_dec(code, 10));
            chk("R7 direct", outdir, exp_dir(4'(code), 1'b1, 4));
            @(negedge clk); le = 1'b0; sel = ~4'(code); #1;
            chk("R2 hold n15", out15, exp_dec(code, 15));
            chk("R2 R5 hold n10", out10, exp_dec(code, 10));
            chk("R7 direct le low", outdir, exp_dir(~4'(code), 1'b0, 4));
            @(negedge clk); sel = 4'(code + 7); #1;
            chk("R2 hold second change n15", out15, exp_dec(code, 15));
        end

        // R7: all 32 combinations of the five master outputs
        for (int c = 0; c < 32; c++) begin
            @(negedge clk); sel = c[3:0]; le = c[4]; #1;
            chk("R7 direct sweep", outdir, exp_dir(c[3:0], c[4], 4));
        end

        // R6: reset while a slave is held in stop
        @(negedge clk); le = 1'b1; sel = 4'd2;
        @(negedge clk); le = 1'b0; sel = 4'd9; #1;
        held = 4'd2;
        chk("R2 held before reset", out15, exp_dec(held, 15));
        rst_n = 1'b0; #1;
        chk("R6 async reset n15", out15, '1);
        chk("R6 async reset n10", out10, '1);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R6 release until enable", out15, '1);
        @(negedge clk); le = 1'b1; sel = 4'd14; #1;
        chk("R3 top index n15", out15, exp_dec(14, 15));
        chk("R5 above count n10", out10, '1);
        @(negedge clk); le = 1'b0;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule